// File: doc/BRIEF.md
# Seconds Timer with Alarm

A bus-attached seconds timer. A slow reference clock, typically 32768 Hz, drives a programmable prescaler. Each time the prescaler completes a period, a free-running 32-bit seconds counter steps by one. Software can read the counter but cannot load it. The only way to change it is to restart it from zero.

A programmable alarm compare value raises a sticky alarm flag on the tick where the counter reaches it. A second sticky flag marks every tick. Reading the status register returns both flags and clears them. Each flag has its own interrupt enable, and one level interrupt line reports any enabled flag that is pending.

The slow clock is not used as a clock inside the block. It is sampled into the bus clock domain through a synchroniser, and its rising edges are counted there. As a result, the counter, alarm and flags all live in the bus domain, and any bus read returns a value that is coherent within itself.

Top module: `sectmr_top`

## Requirements
- R1: After reset, the registers read as follows: MODE (offset 0x0) reads 0x0000_8000, ALARM (offset 0x4) reads 0xFFFF_FFFF, VALUE (offset 0x8) reads 0, and STATUS (offset 0xC) reads 0. The irq output is low.
- R2: VALUE increases by one each time the prescaler has seen P rising edges of slow_clk since the last tick or restart. P is MODE[15:0].
- R3: A write to VALUE has no effect on the counter.
- R4: Writing MODE with bit 18 set clears the counter and the prescaler. Bit 18 always reads back as 0.
- R5: MODE[17:16] and MODE[15:0] read back exactly as written.
- R6: STATUS[1] sets on every tick. STATUS[0] sets on the tick where the counter becomes equal to ALARM.
- R7: While ALARM holds 0xFFFF_FFFF, STATUS[0] never sets.
- R8: A read of STATUS returns the flags and clears them. Read data appears with bus_rvalid one cycle after bus_rd.
- R9: irq goes high one cycle after a flag and its enable are both set. The enables are MODE[16] for STATUS[0] and MODE[17] for STATUS[1]. irq falls once no enabled flag is pending.
- R10: Clearing an enable drops irq but keeps the flag. Setting the enable again raises irq while the flag is still pending.
- R11: If a flag sets in the same cycle as a clearing STATUS read, that read returns the old value and the new flag stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Slow reference clock, sampled asynchronously |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a tick landing in exactly the same bus cycle as a clearing status read. The tick arrives through a synchroniser, an edge detector and the prescaler, so the bench drives slow_clk itself instead of letting it run free. It raises slow_clk on a known bus-clock edge, with the prescaler one edge short of its terminal count. It then times the status read strobe to the exact cycle the flag registers. The same explicit slow-edge control makes every counter value exactly predictable. This also lets the bench check that the interrupt enable can be toggled without losing a pending flag.

// File: rtl/sectmr_pkg.sv
package sectmr_pkg;
  localparam logic [3:0] OFF_MODE   = 4'h0;
  localparam logic [3:0] OFF_ALARM  = 4'h4;
  localparam logic [3:0] OFF_VALUE  = 4'h8;
  localparam logic [3:0] OFF_STATUS = 4'hC;

  // status bit positions; enables sit EN_SHIFT above them in MODE
  localparam int ST_ALARM = 0;
  localparam int ST_INC   = 1;
  localparam int EN_SHIFT = 16;
  localparam int RESTART_BIT = 18;
endpackage

// File: rtl/sectmr_sync.sv
module sectmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/sectmr_count.sv
module sectmr_count #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slow_rise,
  input  logic             restart,
  input  logic [PRE_W-1:0] presc,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] sec,
  output logic             inc_ev,
  output logic             alarm_ev
);
  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] term;
  logic [CNT_W-1:0] sec_nxt;
  logic             wrap;

  // zero wraps to all ones, giving a period of 2**PRE_W
  assign term    = presc - PRE_W'(1);
  assign wrap    = slow_rise && !restart && (pcnt >= term);
  assign sec_nxt = sec + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
      sec  <= '0;
    end else if (slow_rise) begin
      if (pcnt >= term) begin
        pcnt <= '0;
        sec  <= sec_nxt;
      end else begin
        pcnt <= pcnt + PRE_W'(1);
      end
    end
  end

  assign inc_ev   = wrap;
  assign alarm_ev = wrap && (sec_nxt == alarm) && (alarm != '1);

  // R2
  counter_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sec) |-> (sec == $past(sec) + CNT_W'(1)) || (sec == '0));

  // R6
  tick_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_ev) |=> (sec != $past(sec)));
endmodule

// File: rtl/sectmr_status.sv
module sectmr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       alarm_ev,
  input  logic       inc_ev,
  input  logic [1:0] en,
  output logic [1:0] st,
  output logic       irq
);
  import sectmr_pkg::*;

  logic [1:0] ev;

  always_comb begin
    ev = '0;
    ev[ST_ALARM] = alarm_ev;
    ev[ST_INC]   = inc_ev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= '0;
      irq <= 1'b0;
    end else begin
      st  <= (clr ? 2'b00 : st) | ev;
      irq <= |(st & en);
    end
  end

  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && (ev == 2'b00)) |=> (st == 2'b00));

  // R11
  event_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_ev && clr) |=> st[ST_INC]);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(st & en)));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (st != 2'b00 && en == 2'b00 && !clr) |=> (!irq && st != 2'b00));
endmodule

// File: rtl/sectmr_top.sv
module sectmr_top #(
  parameter int          CNT_W       = 32,
  parameter int          PRE_W       = 16,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] PRE_RESET   = 16'h8000,
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  import sectmr_pkg::*;

  localparam int EN_LO = EN_SHIFT;
  localparam int EN_HI = EN_SHIFT + 1;

  logic [PRE_W-1:0] presc_q;
  logic [1:0]       en_q;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] sec;
  logic [1:0]       st;
  logic             slow_rise, inc_ev, alarm_ev;
  logic             sel_mode, sel_alarm, sel_value, sel_status;
  logic             restart, st_clr;

  assign sel_mode   = (bus_addr == ADDR_W'(OFF_MODE));
  assign sel_alarm  = (bus_addr == ADDR_W'(OFF_ALARM));
  assign sel_value  = (bus_addr == ADDR_W'(OFF_VALUE));
  assign sel_status = (bus_addr == ADDR_W'(OFF_STATUS));
  assign restart    = bus_wr && sel_mode && bus_wdata[RESTART_BIT];
  assign st_clr     = bus_rd && sel_status;

  sectmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(slow_clk), .rise(slow_rise)
  );

  sectmr_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
    .clk(clk), .rst(rst), .slow_rise(slow_rise), .restart(restart),
    .presc(presc_q), .alarm(alarm_q), .sec(sec),
    .inc_ev(inc_ev), .alarm_ev(alarm_ev)
  );

  sectmr_status u_status (
    .clk(clk), .rst(rst), .clr(st_clr), .alarm_ev(alarm_ev),
    .inc_ev(inc_ev), .en(en_q), .st(st), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= PRE_W'(PRE_RESET);
      en_q    <= '0;
      alarm_q <= '1;
    end else if (bus_wr) begin
      if (sel_mode) begin
        presc_q <= bus_wdata[PRE_W-1:0];
        en_q    <= bus_wdata[EN_HI:EN_LO];
      end
      if (sel_alarm) alarm_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        bus_rdata <= '0;
        if (sel_mode) begin
          bus_rdata[PRE_W-1:0]   <= presc_q;
          bus_rdata[EN_HI:EN_LO] <= en_q;
        end
        if (sel_alarm)  bus_rdata[CNT_W-1:0] <= alarm_q;
        if (sel_value)  bus_rdata[CNT_W-1:0] <= sec;
        if (sel_status) bus_rdata[1:0]       <= st;
      end
    end
  end

  // R4
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> (sec == '0));

  // R7
  alarm_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st[ST_ALARM]) |-> ($past(alarm_q) != '1));

  // R3
  value_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_value && !slow_rise) |=> $stable(sec));
endmodule

// File: tb/sim_sectmr_top.sv
module sim_sectmr_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        slow_clk = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [3:0] A_MODE = 4'h0, A_ALARM = 4'h4, A_VALUE = 4'h8, A_STAT = 4'hC;
  localparam logic [31:0] RESTART = 32'h0004_0000;
  localparam logic [31:0] EN_ALM  = 32'h0001_0000;
  localparam logic [31:0] EN_INC  = 32'h0002_0000;

  always #5 clk = ~clk;

  sectmr_top u0 (
    .clk(clk), .rst(rst), .slow_clk(slow_clk), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data act=%h exp=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_fail++;
          $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      slow_clk = 1'b1;
      repeat (4) @(negedge clk);
      slow_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    repeat (3) @(negedge clk);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq act=%b exp=%b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq reset");
    rd(A_MODE,  32'h0000_8000, "R1 mode reset");
    rd(A_ALARM, 32'hFFFF_FFFF, "R1 alarm reset");
    rd(A_VALUE, 32'h0, "R1 value reset");
    rd(A_STAT,  32'h0, "R1 status reset");
    // R5 readback
    wr(A_MODE, EN_ALM | EN_INC | 32'h0000_1234);
    rd(A_MODE, 32'h0003_1234, "R5 mode readback");
    wr(A_MODE, 32'h3);
    rd(A_MODE, 32'h3, "R5 prescaler readback");
    // R4 restart
    wr(A_MODE, RESTART | 32'h3);
    rd(A_MODE, 32'h3, "R4 restart bit reads 0");
    rd(A_VALUE, 32'h0, "R4 value after restart");
    // R2 counting, prescaler 3
    pulse(7);
    rd(A_VALUE, 32'd2, "R2 value after 7 edges");
    rd(A_STAT, 32'h2, "R6 increment flag");
    rd(A_STAT, 32'h0, "R8 cleared by read");
    // R3 write ignored
    wr(A_VALUE, 32'h1234);
    rd(A_VALUE, 32'd2, "R3 value write ignored");
    pulse(2);
    rd(A_VALUE, 32'd3, "R2 value after 9 edges");
    rd(A_STAT, 32'h2, "R7 no alarm while all ones");
    // R6 alarm
    wr(A_MODE, RESTART | 32'h3);
    rd(A_VALUE, 32'h0, "R4 second restart");
    wr(A_ALARM, 32'd2);
    rd(A_STAT, 32'h0, "R8 status idle");
    pulse(3);
    rd(A_STAT, 32'h2, "R6 tick before alarm");
    pulse(3);
    rd(A_VALUE, 32'd2, "R2 value at alarm");
    rd(A_STAT, 32'h3, "R6 alarm on match");
    pulse(3);
    rd(A_STAT, 32'h2, "R6 alarm only on match");
    // R9/R10 interrupt enables
    pulse(3);
    chk_irq(1'b0, "R9 masked");
    wr(A_MODE, EN_INC | 32'h3);
    chk_irq(1'b1, "R9 inc enabled");
    wr(A_MODE, 32'h3);
    chk_irq(1'b0, "R10 enable cleared");
    wr(A_MODE, EN_INC | 32'h3);
    chk_irq(1'b1, "R10 enable restored");
    rd(A_STAT, 32'h2, "R10 flag kept");
    chk_irq(1'b0, "R9 irq after clear");
    rd(A_VALUE, 32'd4, "R2 value 4");
    wr(A_ALARM, 32'd5);
    wr(A_MODE, EN_ALM | 32'h3);
    pulse(3);
    chk_irq(1'b1, "R9 alarm enabled");
    rd(A_STAT, 32'h3, "R9 alarm status");
    wr(A_MODE, 32'h3);
    // R11 tick coincident with status read
    pulse(2);
    slow_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(A_STAT, 32'h0, "R11 read returns old flags");
    repeat (2) @(negedge clk);
    slow_clk = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_STAT, 32'h2, "R11 new flag pending");
    rd(A_VALUE, 32'd6, "R2 value 6");
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_checks++; n_fail++;
      $display("FAIL missing read data act=%0d exp=0", exp_q.size());
    end
    finish_run();
  end
endmodule